// File: doc/BRIEF.md
# DDS Control Word Intake Register

This block is the programming front end of a direct digital synthesizer. A 40-bit control word arrives in the write-clock domain, either as five 8-bit bytes presented one after another or as a one-bit serial stream. The word collects in a staging register. An update strobe copies the staged word into the active register. The active word carries a 5-bit phase offset, a 32-bit frequency tuning word, a power-down flag and a reference multiplier enable.

The byte path has no random access. Byte slot 0 is always written first, then slots 1 to 4 in order. Bits left staged from earlier loads stay in place, so a short sequence can change only the leading bytes. The word holds a serial-select bit. If that bit is 1 when a byte-loaded word is committed, the block switches to serial input. From then on each write shifts one bit into the staging register, and only reset brings back the byte path.

The committed word and the input mode are passed into the system clock domain through a toggle handshake. The synthesis datapath reads the fields on that side.

Top module: `dds_word_intake`

## Requirements
- R1: While reset is asserted, and after it is released, the phase, frequency, power-down, multiplier and serial-mode outputs are all 0. The byte pointer starts at slot 0.
- R2: In byte mode, successive writes fill slots 0 to 4 of the 40-bit word. Slot 0 is taken as: bits 7:3 phase (bit 7 MSB), bit 2 power-down, bit 1 serial select, bit 0 multiplier enable. Slots 1 to 4 carry tuning-word bits 31:24, 23:16, 15:8 and 7:0.
- R3: An update strobe returns the byte pointer to slot 0. A sequence that writes fewer than five bytes leaves the staged bytes it did not reach unchanged.
- R4: In byte mode, writes after the fifth are ignored until the next update strobe.
- R5: The outputs change only after an update strobe. Staged bytes are not visible before it.
- R6: Committing a word whose serial-select bit is 1 while in byte mode switches the block to serial mode.
- R7: In serial mode, each write shifts one bit. The first of 40 bits becomes tuning-word bit 0, the bits climb through the tuning word and slot 0, and the 40th bit becomes the phase MSB.
- R8: Serial mode stays set across later commits, including commits whose serial-select bit is 0. Only reset returns the block to byte mode.
- R9: A write presented in the same write-clock cycle as an update strobe is discarded.
- R10: After a commit, the new word and mode appear together on the system-clock outputs within six system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock; samples all inputs |
| sysclk | input | 1 | System clock of the output side |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| wr_en | input | 1 | Write enable for one byte or one serial bit |
| upd | input | 1 | Update strobe: commit staged word |
| byte_in | input | 8 | Parallel byte input |
| ser_in | input | 1 | Serial bit input |
| phase_o | output | 5 | Active phase offset |
| freq_o | output | 32 | Active frequency tuning word |
| pwr_dn_o | output | 1 | Active power-down flag |
| mult_en_o | output | 1 | Active reference multiplier enable |
| serial_mode_o | output | 1 | 1 when the block is in serial mode |

## Verification
On every write-clock cycle, the assertions check the pointer's range and how it advances, its return to slot 0 on a strobe, that the active word holds between strobes and equals the staged word after one, serial-mode entry and its stickiness, and the handshake toggle on each commit. Only the bench's scenarios can show the meaning of the data: which byte lands in which field, the serial bit order, that short reload sequences keep the other staged bytes, and that the values reach the system-clock outputs intact.

// File: rtl/dds_word_pkg.sv
package dds_word_pkg;
  localparam int BYTE_W  = 8;
  localparam int N_BYTES = 5;
  localparam int WORD_W  = BYTE_W * N_BYTES;
  localparam int PH_W    = 5;
  localparam int FREQ_W  = 32;
  localparam int PTR_W   = $clog2(N_BYTES + 1);
  localparam int SEL_BIT = FREQ_W + 1;

  typedef struct packed {
    logic [PH_W-1:0]   phase;
    logic              pwr_dn;
    logic              ser_sel;
    logic              mult_en;
    logic [FREQ_W-1:0] freq;
  } ctl_word_t;
endpackage

// File: rtl/dds_rst_sync.sv
module dds_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] q;
  logic [STAGES-1:0] q_d;

  always_comb q_d = {q[STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) q <= '0;
    else         q <= q_d;
  end

  assign srst_n = q[STAGES-1];
endmodule

// File: rtl/dds_word_stage.sv
module dds_word_stage
  import dds_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upd,
  input  logic              ser_mode,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ser_in,
  output logic [WORD_W-1:0] stage_q,
  output logic [PTR_W-1:0]  ptr_q
);
  logic [WORD_W-1:0] stage_d;
  logic [PTR_W-1:0]  ptr_d;
  logic              stage_en;

  always_comb begin
    stage_d  = stage_q;
    ptr_d    = ptr_q;
    stage_en = 1'b0;
    if (upd) begin
      ptr_d = '0;
    end else if (wr_en) begin
      if (ser_mode) begin
        stage_d  = {ser_in, stage_q[WORD_W-1:1]};
        stage_en = 1'b1;
      end else if (ptr_q < PTR_W'(N_BYTES)) begin
        for (int i = 0; i < N_BYTES; i++) begin
          if (ptr_q == PTR_W'(i))
            stage_d[(N_BYTES-1-i)*BYTE_W +: BYTE_W] = byte_in;
        end
        ptr_d    = ptr_q + PTR_W'(1);
        stage_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      ptr_q   <= '0;
    end else begin
      ptr_q <= ptr_d;
      if (stage_en) stage_q <= stage_d;
    end
  end
endmodule

// File: rtl/dds_commit.sv
module dds_commit
  import dds_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic [WORD_W-1:0] stage_in,
  output logic [WORD_W-1:0] active_q,
  output logic              ser_mode_q,
  output logic              tgl_q
);
  logic ser_mode_d;

  always_comb begin
    ser_mode_d = ser_mode_q;
    if (upd && stage_in[SEL_BIT]) ser_mode_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= '0;
      ser_mode_q <= 1'b0;
      tgl_q      <= 1'b0;
    end else if (upd) begin
      active_q   <= stage_in;
      ser_mode_q <= ser_mode_d;
      tgl_q      <= ~tgl_q;
    end
  end
endmodule

// File: rtl/dds_cdc_xfer.sv
module dds_cdc_xfer #(
  parameter int W           = 41,
  parameter int SYNC_STAGES = 2
) (
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic         src_tgl,
  input  logic [W-1:0] src_data,
  output logic [W-1:0] dst_data
);
  logic [SYNC_STAGES:0] sync_q;
  logic [SYNC_STAGES:0] sync_d;
  logic                 take;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-1:0], src_tgl};
    take   = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      sync_q   <= '0;
      dst_data <= '0;
    end else begin
      sync_q <= sync_d;
      if (take) dst_data <= src_data;
    end
  end
endmodule

// File: rtl/dds_word_intake.sv
module dds_word_intake
  import dds_word_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              sysclk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              upd,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              ser_in,
  output logic [PH_W-1:0]   phase_o,
  output logic [FREQ_W-1:0] freq_o,
  output logic              pwr_dn_o,
  output logic              mult_en_o,
  output logic              serial_mode_o
);
  localparam int XFER_W = WORD_W + 1;

  logic              w_rst_n;
  logic              s_rst_n;
  logic [WORD_W-1:0] stage_q;
  logic [PTR_W-1:0]  ptr_q;
  logic [WORD_W-1:0] active_q;
  logic              ser_mode_q;
  logic              tgl_q;
  logic [XFER_W-1:0] sys_word;
  ctl_word_t         sys_ctl;

  dds_rst_sync #(.STAGES(2)) u_wrst (
    .clk(wclk), .arst_n(rst_n), .srst_n(w_rst_n)
  );

  dds_rst_sync #(.STAGES(2)) u_srst (
    .clk(sysclk), .arst_n(rst_n), .srst_n(s_rst_n)
  );

  dds_word_stage u_stage (
    .clk(wclk), .rst_n(w_rst_n), .wr_en(wr_en), .upd(upd),
    .ser_mode(ser_mode_q), .byte_in(byte_in), .ser_in(ser_in),
    .stage_q(stage_q), .ptr_q(ptr_q)
  );

  dds_commit u_commit (
    .clk(wclk), .rst_n(w_rst_n), .upd(upd), .stage_in(stage_q),
    .active_q(active_q), .ser_mode_q(ser_mode_q), .tgl_q(tgl_q)
  );

  dds_cdc_xfer #(.W(XFER_W), .SYNC_STAGES(SYNC_STAGES)) u_xfer (
    .dst_clk(sysclk), .dst_rst_n(s_rst_n), .src_tgl(tgl_q),
    .src_data({ser_mode_q, active_q}), .dst_data(sys_word)
  );

  assign sys_ctl       = ctl_word_t'(sys_word[WORD_W-1:0]);
  assign phase_o       = sys_ctl.phase;
  assign freq_o        = sys_ctl.freq;
  assign pwr_dn_o      = sys_ctl.pwr_dn;
  assign mult_en_o     = sys_ctl.mult_en;
  assign serial_mode_o = sys_word[WORD_W];
endmodule

// File: rtl/dds_word_intake_chk.sv
module dds_word_intake_chk
  import dds_word_pkg::*;
(
  input logic              wclk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              upd,
  input logic [PTR_W-1:0]  ptr,
  input logic [WORD_W-1:0] stage,
  input logic [WORD_W-1:0] active,
  input logic              ser_mode,
  input logic              tgl
);
  // R4: pointer never passes the last slot
  p_ptr_bound_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    ptr <= PTR_W'(N_BYTES));

  // R2: byte write advances the pointer by one
  p_ptr_step_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (wr_en && !upd && !ser_mode && ptr < PTR_W'(N_BYTES)) |=> ptr == $past(ptr) + PTR_W'(1));

  // R3: strobe returns pointer to slot 0
  p_ptr_home_r3: assert property (@(posedge wclk) disable iff (!rst_n)
    upd |=> ptr == '0);

  // R5: active word holds between strobes
  p_active_hold_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    !upd |=> $stable(active));

  // R5: strobe copies the staged word
  p_active_copy_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    upd |=> active == $past(stage));

  // R6: committed serial select enters serial mode
  p_ser_enter_r6: assert property (@(posedge wclk) disable iff (!rst_n)
    (upd && stage[SEL_BIT]) |=> ser_mode);

  // R8: serial mode is sticky
  p_ser_sticky_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    ser_mode |=> ser_mode);

  // R7: serial writes never move the pointer
  p_ser_ptr_r7: assert property (@(posedge wclk) disable iff (!rst_n)
    (ser_mode && !upd) |=> $stable(ptr));

  // R10: every commit flips the handshake toggle
  p_tgl_flip_r10: assert property (@(posedge wclk) disable iff (!rst_n)
    upd |=> tgl != $past(tgl));
endmodule

bind dds_word_intake dds_word_intake_chk u_chk (
  .wclk(wclk), .rst_n(w_rst_n), .wr_en(wr_en), .upd(upd), .ptr(ptr_q),
  .stage(stage_q), .active(active_q), .ser_mode(ser_mode_q), .tgl(tgl_q)
);

// File: tb/dds_word_intake_bench.sv
module dds_word_intake_bench;
  localparam int CLK_PERIOD  = 10;
  localparam int SCLK_PERIOD = 14;

  logic        wclk = 1'b0;
  logic        sysclk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic        upd;
  logic [7:0]  byte_in;
  logic        ser_in;
  logic [4:0]  phase_o;
  logic [31:0] freq_o;
  logic        pwr_dn_o;
  logic        mult_en_o;
  logic        serial_mode_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) wclk = ~wclk;
  always #(SCLK_PERIOD/2) sysclk = ~sysclk;

  dds_word_intake u_dds_word_intake (
    .wclk(wclk), .sysclk(sysclk), .rst_n(rst_n), .wr_en(wr_en), .upd(upd),
    .byte_in(byte_in), .ser_in(ser_in), .phase_o(phase_o), .freq_o(freq_o),
    .pwr_dn_o(pwr_dn_o), .mult_en_o(mult_en_o), .serial_mode_o(serial_mode_o)
  );

  task automatic chk(input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [4:0] ph, input logic [31:0] fr,
                         input logic pd, input logic mu, input logic sm);
    chk({req, " phase"}, 40'(phase_o), 40'(ph));
    chk({req, " freq"}, 40'(freq_o), 40'(fr));
    chk({req, " pwr_dn"}, 40'(pwr_dn_o), 40'(pd));
    chk({req, " mult"}, 40'(mult_en_o), 40'(mu));
    chk({req, " mode"}, 40'(serial_mode_o), 40'(sm));
  endtask

  task automatic put_byte(input logic [7:0] b);
    @(negedge wclk); wr_en = 1'b1; byte_in = b;
    @(negedge wclk); wr_en = 1'b0;
  endtask

  task automatic strobe();
    @(negedge wclk); upd = 1'b1;
    @(negedge wclk); upd = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(posedge sysclk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge wclk); rst_n = 1'b0;
    repeat (3) @(negedge wclk);
    rst_n = 1'b1;
    repeat (4) @(negedge wclk);
    settle();
  endtask

  task automatic t_reset();
    rst_n = 1'b0; wr_en = 1'b0; upd = 1'b0; byte_in = '0; ser_in = 1'b0;
    repeat (3) @(negedge wclk);
    #1;
    chk_out("R1 during reset", 5'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge wclk);
    settle();
    chk_out("R1 after reset", 5'd0, 32'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_full_load();
    put_byte(8'h09); put_byte(8'h0E); put_byte(8'h38); put_byte(8'hE3); put_byte(8'h8E);
    settle();
    chk("R5 staged hidden", 40'(freq_o), 40'd0);
    strobe(); settle();
    chk_out("R2 full load", 5'd1, 32'h0E38E38E, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_partial();
    put_byte(8'hFC);
    strobe(); settle();
    chk_out("R3 slot0 only", 5'd31, 32'h0E38E38E, 1'b1, 1'b0, 1'b0);
    put_byte(8'h00); put_byte(8'hAB);
    strobe(); settle();
    chk_out("R3 slot0+1", 5'd0, 32'hAB38E38E, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_overflow();
    put_byte(8'h00); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33); put_byte(8'h44);
    put_byte(8'h55);
    strobe(); settle();
    chk_out("R4 extra write", 5'd0, 32'h11223344, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_collide();
    put_byte(8'h10);
    @(negedge wclk); wr_en = 1'b1; upd = 1'b1; byte_in = 8'h99;
    @(negedge wclk); wr_en = 1'b0; upd = 1'b0;
    settle();
    chk_out("R9 write with strobe", 5'd2, 32'h11223344, 1'b0, 1'b0, 1'b0);
    put_byte(8'h18); put_byte(8'h55);
    strobe(); settle();
    chk_out("R9 pointer home", 5'd3, 32'h55223344, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_enter_serial();
    put_byte(8'h02);
    settle();
    chk("R6 mode before commit", 40'(serial_mode_o), 40'd0);
    strobe(); settle();
    chk_out("R6 enter serial", 5'd0, 32'h55223344, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic t_serial();
    logic [39:0] w;
    w = {8'h48, 32'hDEADBEEF};
    for (int i = 0; i < 40; i++) begin
      @(negedge wclk); wr_en = 1'b1; ser_in = w[i]; byte_in = 8'hFF;
    end
    @(negedge wclk); wr_en = 1'b0; ser_in = 1'b0;
    strobe(); settle();
    chk_out("R7 serial order", 5'd9, 32'hDEADBEEF, 1'b0, 1'b0, 1'b1);
    w = {8'h07, 32'h00000001};
    for (int i = 0; i < 40; i++) begin
      @(negedge wclk); wr_en = 1'b1; ser_in = w[i];
    end
    @(negedge wclk); wr_en = 1'b0;
    strobe(); settle();
    chk_out("R8 sticky serial", 5'd0, 32'h00000001, 1'b1, 1'b1, 1'b1);
  endtask

  task automatic t_reset_exit();
    do_reset();
    chk_out("R8 reset exits serial", 5'd0, 32'd0, 1'b0, 1'b0, 1'b0);
    put_byte(8'h21); put_byte(8'hC0);
    strobe(); settle();
    chk_out("R1 byte path back", 5'd4, 32'hC0000000, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic t_latency();
    put_byte(8'h0C);
    strobe();
    repeat (6) @(posedge sysclk);
    #1;
    chk_out("R10 six sysclk", 5'd1, 32'hC0000000, 1'b1, 1'b0, 1'b0);
  endtask

  initial begin
    t_reset();
    t_full_load();
    t_partial();
    t_overflow();
    t_collide();
    t_enter_serial();
    t_serial();
    t_reset_exit();
    t_latency();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual running expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule